// File: doc/BRIEF.md
# Card Command Issue Unit

This unit issues one command at a time to a memory card and collects the card's reply. Software first loads a 32-bit argument. It then writes a command word that carries a 6-bit command index, a set of option bits and an enable bit. The write with the enable bit set starts the command. The unit asks the card-line serializer to transmit the index and argument. For a command that expects a reply, it then waits for the response start bit and the response itself. The result is placed in a response-index register and in four 32-bit response words. Completion and each kind of failure are recorded as sticky status flags.

The serial command line sits outside this block. A transmit request/done handshake stands for it on one side. On the other side stand a start-bit strobe and a response strobe that carries the decoded index, payload and checker verdicts. The response timeout is measured in card-clock ticks, which arrive on a qualifier input.

Top module: `card_cmd_path`

## Requirements
- R1: After reset, every register reads zero, `tx_req` is low and the active bit (status bit 11) is clear.
- R2: A write to the command word (word address 1) is accepted while the unit is idle. If bit 10 is set, the write starts a command. `tx_req` then rises and presents bits [5:0] as `tx_index` and the argument register (word address 0) as `tx_arg`.
- R3: A write to the command word with bit 10 clear starts nothing. The value is still stored and reads back.
- R4: A command with bit 6 clear completes on `tx_done`. It sets command-sent (status bit 7) and does not set response-end (status bit 6).
- R5: A command with bit 6 set and bit 7 clear completes on an error-free response. It sets response-end (status bit 6). The index returned by the card lands in the response-index register (word address 2). The response bits [31:0] land in response word 0 (word address 3), and response words 1 to 3 keep their values.
- R6: A command with bits 6 and 7 set stores a 128-bit response. Bits [127:96] go to response word 0 (address 3), [95:64] to address 4, [63:32] to address 5 and [31:0] to address 6.
- R7: A response with a start-bit error sets status bit 9. A response with only a CRC failure sets status bit 0. In both cases status bit 6 stays clear.
- R8: Once the command has been sent, a response start bit must arrive within 64 `card_tick` cycles. If the 64th tick passes without one, command-timeout (status bit 2) is set and the unit goes idle. Cycles without a tick do not count.
- R9: With bit 8 set in the command word (wait for interrupt), no timeout is raised however long the response takes.
- R10: With bit 9 set in the command word (wait for pending), transmission is held back until `cmd_go` is high.
- R11: Status bits 0, 2, 6, 7 and 9 are sticky. They fall only when a one is written to the same bit position of the clear register (word address 8). Starting a new command does not clear them.
- R12: While a command is active, status bit 11 reads one. Writes to the command word and to the argument register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| card_tick | input | 1 | Card-clock qualifier for the timeout count |
| cmd_go | input | 1 | Release for commands that wait for pending |
| tx_req | output | 1 | Request to transmit the command |
| tx_index | output | 6 | Command index to transmit |
| tx_arg | output | 32 | Argument to transmit |
| tx_done | input | 1 | Command has been sent on the line |
| rsp_start | input | 1 | Response start bit seen |
| rsp_valid | input | 1 | Response fully received |
| rsp_index | input | 6 | Index carried by the response |
| rsp_data | input | 128 | Response payload |
| rsp_crc_fail | input | 1 | Response CRC check failed |
| rsp_start_err | input | 1 | Response start-bit error |

## Verification
If the sequencer held a wrong state, the fault would surface at the ports within one cycle of the next handshake. It could show as a `tx_req` that appears without a start write, or one that is missing while the active bit is set. It could also show as a completion flag of the wrong kind, as the response-end and command-sent flags depend on the latched command word. A miscounted timeout window shows up as a timeout flag one tick early or late, so the bench samples the status on both sides of the 64th tick. A wrong word order in response capture, or a lost sticky bit, can only be seen when the registers are read. The bench therefore reads back after every command, and it does not clear the flags before the next command.

// File: rtl/card_cmd_path.sv
module card_cmd_path #(
  parameter int DW = 32,
  parameter int IW = 6,
  parameter int AW = 4,
  parameter int RSP_WORDS = 4,
  parameter int TIMEOUT_TICKS = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [AW-1:0]           reg_addr,
  input  logic [DW-1:0]           reg_wdata,
  output logic [DW-1:0]           reg_rdata,
  input  logic                    card_tick,
  input  logic                    cmd_go,
  output logic                    tx_req,
  output logic [IW-1:0]           tx_index,
  output logic [DW-1:0]           tx_arg,
  input  logic                    tx_done,
  input  logic                    rsp_start,
  input  logic                    rsp_valid,
  input  logic [IW-1:0]           rsp_index,
  input  logic [RSP_WORDS*DW-1:0] rsp_data,
  input  logic                    rsp_crc_fail,
  input  logic                    rsp_start_err
);

  localparam int TW = $clog2(TIMEOUT_TICKS + 1);
  localparam int SW = 11;
  localparam logic [AW-1:0] A_ARG  = AW'(0);
  localparam logic [AW-1:0] A_CMD  = AW'(1);
  localparam logic [AW-1:0] A_RIDX = AW'(2);
  localparam logic [AW-1:0] A_RSP  = AW'(3);
  localparam logic [AW-1:0] A_STS  = AW'(3 + RSP_WORDS);
  localparam logic [AW-1:0] A_CLR  = AW'(4 + RSP_WORDS);

  localparam int C_WAIT = 6;
  localparam int C_LONG = 7;
  localparam int C_IRQ  = 8;
  localparam int C_PEND = 9;
  localparam int C_EN   = 10;

  localparam int B_CRC  = 0;
  localparam int B_TO   = 2;
  localparam int B_REND = 6;
  localparam int B_SENT = 7;
  localparam int B_SBE  = 9;
  localparam logic [SW-1:0] STICKY = SW'((1 << B_CRC) | (1 << B_TO) | (1 << B_REND)
                                         | (1 << B_SENT) | (1 << B_SBE));

  typedef enum logic [2:0] {S_IDLE, S_PEND, S_SEND, S_WAIT, S_RECV} st_t;

  st_t              st_q;
  logic [DW-1:0]    arg_q;
  logic [DW-1:0]    cmd_q;
  logic [IW-1:0]    ridx_q;
  logic [DW-1:0]    rsp_q [RSP_WORDS];
  logic [SW-1:0]    sts_q;
  logic [SW-1:0]    sts_set;
  logic [TW-1:0]    tcnt_q;

  wire idle     = (st_q == S_IDLE);
  wire wr_cmd   = reg_wr && reg_addr == A_CMD;
  wire wr_clr   = reg_wr && reg_addr == A_CLR;
  wire start    = idle && wr_cmd && reg_wdata[C_EN];
  wire tick_hit = card_tick && !cmd_q[C_IRQ];
  wire tmo_last = tcnt_q == TW'(TIMEOUT_TICKS - 1);

  assign tx_req   = (st_q == S_SEND);
  assign tx_index = cmd_q[IW-1:0];
  assign tx_arg   = arg_q;

  always_comb begin
    sts_set = '0;
    if (st_q == S_SEND && tx_done && !cmd_q[C_WAIT]) sts_set[B_SENT] = 1'b1;
    if (st_q == S_WAIT && !rsp_start && tick_hit && tmo_last) sts_set[B_TO] = 1'b1;
    if (st_q == S_RECV && rsp_valid) begin
      if (rsp_start_err)     sts_set[B_SBE]  = 1'b1;
      else if (rsp_crc_fail) sts_set[B_CRC]  = 1'b1;
      else                   sts_set[B_REND] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      arg_q  <= '0;
      cmd_q  <= '0;
      tcnt_q <= '0;
    end else begin
      if (idle && reg_wr && reg_addr == A_ARG) arg_q <= reg_wdata;
      if (idle && wr_cmd) cmd_q <= reg_wdata;
      case (st_q)
        S_IDLE: if (start) st_q <= reg_wdata[C_PEND] ? S_PEND : S_SEND;
        S_PEND: if (cmd_go) st_q <= S_SEND;
        S_SEND: if (tx_done) begin
          tcnt_q <= '0;
          st_q   <= cmd_q[C_WAIT] ? S_WAIT : S_IDLE;
        end
        S_WAIT: begin
          if (rsp_start) st_q <= S_RECV;
          else if (tick_hit) begin
            if (tmo_last) st_q <= S_IDLE;
            else tcnt_q <= tcnt_q + 1'b1;
          end
        end
        S_RECV: if (rsp_valid) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else begin
      sts_q <= (sts_q & ~(wr_clr ? (reg_wdata[SW-1:0] & STICKY) : '0)) | sts_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ridx_q <= '0;
      for (int i = 0; i < RSP_WORDS; i++) rsp_q[i] <= '0;
    end else if (st_q == S_RECV && rsp_valid) begin
      ridx_q <= rsp_index;
      if (cmd_q[C_LONG]) begin
        for (int i = 0; i < RSP_WORDS; i++)
          rsp_q[i] <= rsp_data[(RSP_WORDS-1-i)*DW +: DW];
      end else begin
        rsp_q[0] <= rsp_data[DW-1:0];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_ARG) reg_rdata = arg_q;
    else if (reg_addr == A_CMD) reg_rdata = cmd_q;
    else if (reg_addr == A_RIDX) reg_rdata = DW'(ridx_q);
    else if (reg_addr == A_STS) reg_rdata = DW'({!idle, sts_q});
    else begin
      for (int i = 0; i < RSP_WORDS; i++)
        if (reg_addr == A_RSP + AW'(i)) reg_rdata = rsp_q[i];
    end
  end

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_clr |=> (($past(sts_q) & ~sts_q) == '0));

  p_sent_needs_noresp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[B_SENT]) |-> !cmd_q[C_WAIT]);

  p_rend_needs_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[B_REND]) |-> cmd_q[C_WAIT]);

  p_busy_cmd_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && wr_cmd) |=> $stable(cmd_q));

  p_pend_holds_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_PEND && !cmd_go) |=> !tx_req);

  p_timeout_from_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[B_TO]) |-> $past(st_q == S_WAIT));

  p_no_timeout_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT && cmd_q[C_IRQ]) |=> !$rose(sts_q[B_TO]));

endmodule

// File: tb/test_card_cmd_path.sv
module test_card_cmd_path;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [3:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         card_tick = 1'b1;
  logic         cmd_go = 1'b0;
  logic         tx_req;
  logic [5:0]   tx_index;
  logic [31:0]  tx_arg;
  logic         tx_done = 1'b0;
  logic         rsp_start = 1'b0;
  logic         rsp_valid = 1'b0;
  logic [5:0]   rsp_index = '0;
  logic [127:0] rsp_data = '0;
  logic         rsp_crc_fail = 1'b0;
  logic         rsp_start_err = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [37:0] exp_q[$];
  logic tx_req_d = 1'b0;

  card_cmd_path i_card_cmd_path (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .card_tick(card_tick),
    .cmd_go(cmd_go), .tx_req(tx_req), .tx_index(tx_index), .tx_arg(tx_arg),
    .tx_done(tx_done), .rsp_start(rsp_start), .rsp_valid(rsp_valid),
    .rsp_index(rsp_index), .rsp_data(rsp_data), .rsp_crc_fail(rsp_crc_fail),
    .rsp_start_err(rsp_start_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && tx_req && !tx_req_d) begin
      if (exp_q.size() == 0) check("R2 unexpected tx_req", 1'b1, 1'b0);
      else begin
        logic [37:0] e;
        e = exp_q.pop_front();
        check("R2 issued index/argument", {tx_index, tx_arg}, e);
      end
    end
    tx_req_d <= tx_req;
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1 check(req, reg_rdata, exp);
  endtask

  task automatic issue(input logic [31:0] arg, input logic [31:0] cmd);
    wr(4'd0, arg);
    exp_q.push_back({cmd[5:0], arg});
    wr(4'd1, cmd);
  endtask

  task automatic do_send();
    @(negedge clk);
    while (!tx_req) @(negedge clk);
    tx_done = 1'b1;
    @(posedge clk);
    #1 tx_done = 1'b0;
  endtask

  task automatic give_start();
    @(negedge clk);
    rsp_start = 1'b1;
    @(posedge clk);
    #1 rsp_start = 1'b0;
  endtask

  task automatic give_rsp(input logic [5:0] idx, input logic [127:0] d, input logic crc, input logic sbe);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_index = idx; rsp_data = d; rsp_crc_fail = crc; rsp_start_err = sbe;
    @(posedge clk);
    #1 rsp_valid = 1'b0; rsp_crc_fail = 1'b0; rsp_start_err = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd("R1 status after reset", 4'd7, 32'h0);
    rd("R1 command after reset", 4'd1, 32'h0);
    rd("R1 response word 0 after reset", 4'd3, 32'h0);
    check("R1 tx_req after reset", tx_req, 1'b0);

    // R3: enable clear starts nothing
    wr(4'd1, 32'h0000_0011);
    repeat (3) @(posedge clk);
    #1 check("R3 no tx_req without enable", tx_req, 1'b0);
    rd("R3 no active without enable", 4'd7, 32'h0);
    rd("R3 command value stored", 4'd1, 32'h0000_0011);

    // R4: no-response command
    issue(32'hCAFE_0001, 32'h0000_0400 | 32'd0);
    do_send();
    rd("R4 sent flag only", 4'd7, 32'h0000_0080);

    // R11: new command does not clear, then clear
    issue(32'h1234_5678, 32'h0000_0400 | 32'd13);
    #1 rd("R12 active while sending", 4'd7, 32'h0000_0880);
    do_send();
    rd("R11 flag sticky across command", 4'd7, 32'h0000_0080);
    wr(4'd8, 32'h0000_0040);
    rd("R11 clearing other bit leaves sent", 4'd7, 32'h0000_0080);
    wr(4'd8, 32'h0000_07FF);
    rd("R11 cleared", 4'd7, 32'h0);

    // R5 short response, R12 busy writes ignored
    issue(32'h0000_AAAA, 32'h0000_0440 | 32'd17);
    do_send();
    wr(4'd1, 32'h0000_0400 | 32'd5);
    wr(4'd0, 32'hDEAD_DEAD);
    rd("R12 active while waiting", 4'd7, 32'h0000_0800);
    give_start();
    give_rsp(6'd17, {32'h1, 32'h2, 32'h3, 32'h0000_0900}, 1'b0, 1'b0);
    rd("R5 response end", 4'd7, 32'h0000_0040);
    rd("R5 response index", 4'd2, 32'd17);
    rd("R5 short word", 4'd3, 32'h0000_0900);
    rd("R5 word 1 untouched", 4'd4, 32'h0);
    rd("R12 command write ignored", 4'd1, 32'h0000_0440 | 32'd17);
    rd("R12 argument write ignored", 4'd0, 32'h0000_AAAA);
    wr(4'd8, 32'h0000_07FF);

    // R6 long response
    issue(32'h0, 32'h0000_04C0 | 32'd2);
    do_send();
    give_start();
    give_rsp(6'd63, {32'hA0A0_0003, 32'hB1B1_0002, 32'hC2C2_0001, 32'hD3D3_0000}, 1'b0, 1'b0);
    rd("R6 word 0 msw", 4'd3, 32'hA0A0_0003);
    rd("R6 word 1", 4'd4, 32'hB1B1_0002);
    rd("R6 word 2", 4'd5, 32'hC2C2_0001);
    rd("R6 word 3 lsw", 4'd6, 32'hD3D3_0000);
    rd("R5 long response index", 4'd2, 32'd63);
    wr(4'd8, 32'h0000_07FF);

    // R7 CRC failure then start-bit error
    issue(32'h0, 32'h0000_0440 | 32'd7);
    do_send();
    give_start();
    give_rsp(6'd7, 128'h55, 1'b1, 1'b0);
    rd("R7 crc fail flag", 4'd7, 32'h0000_0001);
    wr(4'd8, 32'h0000_07FF);
    issue(32'h0, 32'h0000_0440 | 32'd8);
    do_send();
    give_start();
    give_rsp(6'd8, 128'h66, 1'b1, 1'b1);
    rd("R7 start-bit error flag", 4'd7, 32'h0000_0200);
    wr(4'd8, 32'h0000_07FF);

    // R8 timeout with gated ticks
    card_tick = 1'b0;
    issue(32'h0, 32'h0000_0440 | 32'd9);
    do_send();
    repeat (10) @(posedge clk);
    #1 card_tick = 1'b1;
    repeat (63) @(posedge clk);
    #1 rd("R8 no timeout at 63 ticks", 4'd7, 32'h0000_0800);
    @(posedge clk);
    #1 rd("R8 timeout at 64 ticks", 4'd7, 32'h0000_0004);
    wr(4'd8, 32'h0000_07FF);

    // R9 wait-for-interrupt suppresses timeout
    issue(32'h0, 32'h0000_0540 | 32'd10);
    do_send();
    repeat (100) @(posedge clk);
    #1 rd("R9 no timeout while waiting", 4'd7, 32'h0000_0800);
    give_start();
    give_rsp(6'd10, 128'h77, 1'b0, 1'b0);
    rd("R9 completes later", 4'd7, 32'h0000_0040);
    wr(4'd8, 32'h0000_07FF);

    // R10 wait-for-pending
    issue(32'h0000_0BEE, 32'h0000_0600 | 32'd11);
    repeat (5) @(posedge clk);
    #1 check("R10 tx held without go", tx_req, 1'b0);
    rd("R10 active while pending", 4'd7, 32'h0000_0800);
    @(negedge clk) cmd_go = 1'b1;
    do_send();
    cmd_go = 1'b0;
    rd("R10 sent after go", 4'd7, 32'h0000_0080);

    repeat (2) @(posedge clk);
    check("R2 all commands issued", exp_q.size(), 0);
    finish_run();
  end
endmodule